// File: doc/BRIEF.md
# Half-Precision Square Root Unit

This unit computes the IEEE 754 square root of one binary16 operand (1 sign bit, 5 exponent bits, 10 fraction bits). A caller presents the operand and a 2-bit rounding-mode selector with a one-cycle `start_i` pulse while the unit is idle. The unit sorts out the special encodings, normalises subnormal inputs and makes the exponent even. It then runs a restoring digit-by-digit root that produces one result bit per cycle. The answer comes back with a one-cycle `done_o` pulse, together with three per-operation exception flags: invalid, denormal operand and inexact.

The mantissa root yields 12 bits: 11 significant bits plus a guard bit. A sticky bit is taken from the final remainder. The rounding step uses these bits under the selected mode, and a carry out of the mantissa raises the exponent by one. The root of any finite binary16 value is a finite normal number or zero, so the result never overflows or underflows.

Top module: `fp16_sqrt_core`

## Requirements
- R1: A `start_i` pulse accepted while idle produces exactly one `done_o` pulse, one cycle wide. It is seen 14 rising edges after the accepting edge, counting that edge as the first. `result_o` and the three flags are valid while `done_o` is high, and after reset all outputs are 0.
- R2: A `start_i` seen while an operation is in progress is ignored. It neither changes the result of the running operation nor produces an extra `done_o`.
- R3: For a positive finite non-zero operand, `result_o` is the square root rounded by `rmode_i`: 00 = nearest, ties to even; 01 = toward minus infinity; 10 = toward plus infinity; 11 = toward zero.
- R4: `flag_inexact_o` is 1 exactly when the rounded result differs from the exact root. It is 0 for all special-case operands.
- R5: A subnormal operand (exponent field 0, fraction non-zero) sets `flag_denormal_o`, whatever its sign. A positive subnormal still yields its correctly rounded root.
- R6: +0 (0x0000) returns +0 and -0 (0x8000) returns -0, with no flag set.
- R7: +infinity (0x7C00) returns +infinity with no flag. Every negative non-zero operand that is not a NaN, including -infinity, returns the default quiet NaN 0x7E00 and sets `flag_invalid_o`.
- R8: A NaN input (exponent field 31, fraction non-zero) returns the same bits with fraction bit 9 (the quiet bit) forced to 1. `flag_invalid_o` is set only when that bit was 0 on input.
- R9: When rounding carries out of the mantissa, the exponent rises by one and the fraction becomes 0. For example, 0x43FF under mode 10 gives 0x4000, while the other modes give 0x3FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| operand_i | input | 16 | binary16 operand, sampled with `start_i` |
| rmode_i | input | 2 | Rounding mode, sampled with `start_i` |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | 16 | binary16 square root |
| flag_invalid_o | output | 1 | Invalid operation for this result |
| flag_denormal_o | output | 1 | Operand was subnormal |
| flag_inexact_o | output | 1 | Result was rounded |

## Verification
Perfect squares such as 4.0, 1.0 and the smallest normal are run in all four modes, where the result must not change and inexact must stay low. Operands such as 2.0, 3.0 and the largest finite value have irrational roots, so they separate rounding up from truncation and show the mode decoding. The value 0x43FF pulls the carry-out exponent bump apart from the plain path, and subnormals with the leading one at several positions test the leading-zero normalisation and the odd-exponent shift. A set of pseudo-random positive normals with mixed modes is checked against a real-arithmetic reference. The special encodings (signed zeros, infinities, quiet and signaling NaNs of both signs, negative finite and negative subnormal values) tell the bypass path apart from the computed one. A second start issued mid-operation shows that the running operation is kept.

// File: rtl/fp16_sqrt_pkg.sv
package fp16_sqrt_pkg;

    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int FP_W    = 1 + EXP_W + FRAC_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int MANT_W  = FRAC_W + 1;          // with hidden one
    localparam int ROOT_W  = MANT_W + 1;          // plus guard bit
    localparam int RAD_W   = 2 * ROOT_W;          // radicand bits consumed
    localparam int REM_W   = ROOT_W + 2;          // partial remainder
    localparam int EXPS_W  = EXP_W + 3;           // signed exponent math
    localparam int LZ_W    = $clog2(FRAC_W + 1);
    localparam int CNT_W   = $clog2(ROOT_W + 1);

    localparam logic [FP_W-1:0] DEFAULT_QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef logic signed [EXPS_W-1:0] sexp_t;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROOT,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic              bypass;     // result fixed without root
        logic [FP_W-1:0]   fixed_res;
        logic              invalid;
        logic              denorm;
        logic [RAD_W-1:0]  radicand;
        logic [EXP_W-1:0]  res_exp;    // biased, before carry
    } unpack_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FRAC_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n = n + 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fp16_sqrt_unpack.sv
module fp16_sqrt_unpack
    import fp16_sqrt_pkg::*;
(
    input  logic [FP_W-1:0] op_i,
    output unpack_t         unp_o
);

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              is_zero, is_sub, is_inf, is_nan;
    logic [LZ_W-1:0]   lz;
    logic [LZ_W-1:0]   shamt;
    logic [MANT_W-1:0] mant;
    logic [ROOT_W-1:0] mant_even;
    sexp_t             unb, unb_even, half;

    assign sgn = op_i[FP_W-1];
    assign ex  = op_i[FP_W-2 -: EXP_W];
    assign fr  = op_i[FRAC_W-1:0];

    assign is_zero = (ex == '0) && (fr == '0);
    assign is_sub  = (ex == '0) && (fr != '0);
    assign is_inf  = (ex == '1) && (fr == '0);
    assign is_nan  = (ex == '1) && (fr != '0);

    assign lz    = lead_zeros(fr);
    assign shamt = lz + 1'b1;

    always_comb begin
        if (is_sub) begin
            mant = MANT_W'({1'b0, fr} << shamt);
            unb  = sexp_t'(1 - BIAS) - sexp_t'(shamt);
        end else begin
            mant = {1'b1, fr};
            unb  = sexp_t'(ex) - sexp_t'(BIAS);
        end
        if (unb[0]) begin
            mant_even = {mant, 1'b0};
            unb_even  = unb - sexp_t'(1);
        end else begin
            mant_even = {1'b0, mant};
            unb_even  = unb;
        end
        half = unb_even >>> 1;
    end

    always_comb begin
        unp_o.radicand  = {mant_even, {ROOT_W{1'b0}}};
        unp_o.res_exp   = EXP_W'(half + sexp_t'(BIAS));
        unp_o.denorm    = is_sub;
        unp_o.bypass    = 1'b1;
        unp_o.invalid   = 1'b0;
        unp_o.fixed_res = op_i;
        if (is_nan) begin
            unp_o.fixed_res[FRAC_W-1] = 1'b1;
            unp_o.invalid             = !fr[FRAC_W-1];
        end else if (is_zero) begin
            unp_o.fixed_res = op_i;
        end else if (sgn) begin
            unp_o.fixed_res = DEFAULT_QNAN;
            unp_o.invalid   = 1'b1;
        end else if (is_inf) begin
            unp_o.fixed_res = op_i;
        end else begin
            unp_o.bypass = 1'b0;
        end
    end

endmodule

// File: rtl/fp16_sqrt_root.sv
module fp16_sqrt_root
    import fp16_sqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [RAD_W-1:0]  radicand_i,
    input  logic              step_i,
    output logic [ROOT_W-1:0] root_o,
    output logic              sticky_o
);

    logic [RAD_W-1:0]  pend_q;
    logic [REM_W-1:0]  rem_q;
    logic [ROOT_W-1:0] root_q;
    logic [REM_W-1:0]  rem_sh, trial;
    logic              fits;

    assign rem_sh = {rem_q[REM_W-3:0], pend_q[RAD_W-1 -: 2]};
    assign trial  = {root_q, 2'b01};
    assign fits   = (rem_sh >= trial);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (load_i) begin
            pend_q <= radicand_i;
            rem_q  <= '0;
            root_q <= '0;
        end else if (step_i) begin
            pend_q <= pend_q << 2;
            rem_q  <= fits ? (rem_sh - trial) : rem_sh;
            root_q <= {root_q[ROOT_W-2:0], fits};
        end
    end

    assign root_o   = root_q;
    assign sticky_o = |rem_q;

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rem_q <= {1'b0, root_q, 1'b0});

endmodule

// File: rtl/fp16_sqrt_round.sv
module fp16_sqrt_round
    import fp16_sqrt_pkg::*;
(
    input  logic [ROOT_W-1:0] root_i,
    input  logic              sticky_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  rmode_e            rmode_i,
    output logic [FP_W-1:0]   result_o,
    output logic              inexact_o
);

    logic              guard, lsb, bump;
    logic [MANT_W:0]   sum;
    logic              carry;

    assign guard = root_i[0];
    assign lsb   = root_i[1];

    always_comb begin
        case (rmode_i)
            RM_NEAREST: bump = guard & (sticky_i | lsb);
            RM_UP:      bump = guard | sticky_i;
            default:    bump = 1'b0;  // operand positive: down == zero
        endcase
    end

    assign sum       = {1'b0, root_i[ROOT_W-1:1]} + {{MANT_W{1'b0}}, bump};
    assign carry     = sum[MANT_W];
    assign result_o  = {1'b0, exp_i + {{(EXP_W-1){1'b0}}, carry}, sum[FRAC_W-1:0]};
    assign inexact_o = guard | sticky_i;

endmodule

// File: rtl/fp16_sqrt_core.sv
module fp16_sqrt_core
    import fp16_sqrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [FP_W-1:0]  operand_i,
    input  logic [1:0]       rmode_i,
    output logic             done_o,
    output logic [FP_W-1:0]  result_o,
    output logic             flag_invalid_o,
    output logic             flag_denormal_o,
    output logic             flag_inexact_o
);

    state_e            state_q;
    logic [CNT_W-1:0]  cnt_q;
    unpack_t           unp, unp_q;
    rmode_e            rm_q;
    logic              accept;
    logic [ROOT_W-1:0] root;
    logic              sticky;
    logic [FP_W-1:0]   rnd_res;
    logic              rnd_inexact;

    assign accept = (state_q == ST_IDLE) && start_i;

    fp16_sqrt_unpack u_unpack (
        .op_i  (operand_i),
        .unp_o (unp)
    );

    fp16_sqrt_root u_root (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .radicand_i (unp.radicand),
        .step_i     (state_q == ST_ROOT),
        .root_o     (root),
        .sticky_o   (sticky)
    );

    fp16_sqrt_round u_round (
        .root_i    (root),
        .sticky_i  (sticky),
        .exp_i     (unp_q.res_exp),
        .rmode_i   (rm_q),
        .result_o  (rnd_res),
        .inexact_o (rnd_inexact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q         <= ST_IDLE;
            cnt_q           <= '0;
            unp_q           <= '0;
            rm_q            <= RM_NEAREST;
            done_o          <= 1'b0;
            result_o        <= '0;
            flag_invalid_o  <= 1'b0;
            flag_denormal_o <= 1'b0;
            flag_inexact_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    unp_q   <= unp;
                    rm_q    <= rmode_e'(rmode_i);
                    cnt_q   <= CNT_W'(ROOT_W);
                    state_q <= ST_ROOT;
                end
                ST_ROOT: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_q <= ST_FIN;
                end
                default: begin
                    done_o          <= 1'b1;
                    result_o        <= unp_q.bypass ? unp_q.fixed_res : rnd_res;
                    flag_invalid_o  <= unp_q.invalid;
                    flag_denormal_o <= unp_q.denorm;
                    flag_inexact_o  <= !unp_q.bypass && rnd_inexact;
                    state_q         <= ST_IDLE;
                end
            endcase
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(unp_q) && $stable(rm_q));

    // R7
    invalid_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && flag_invalid_o) |->
            (result_o[FP_W-2 -: EXP_W] == '1) && result_o[FRAC_W-1]);

    // R4
    inexact_finite_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && flag_inexact_o) |->
            !result_o[FP_W-1] && (result_o[FP_W-2 -: EXP_W] != '0) &&
            (result_o[FP_W-2 -: EXP_W] != '1));

endmodule

// File: tb/fp16_sqrt_core_tb_top.sv
`timescale 1ns/1ps
module fp16_sqrt_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        done_o;
    logic [15:0] result_o;
    logic        flag_invalid_o, flag_denormal_o, flag_inexact_o;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    typedef struct {
        logic [15:0] res;
        logic        inv;
        logic        den;
        logic        inx;
        int          due;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    fp16_sqrt_core dut_i (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .operand_i       (operand_i),
        .rmode_i         (rmode_i),
        .done_o          (done_o),
        .result_o        (result_o),
        .flag_invalid_o  (flag_invalid_o),
        .flag_denormal_o (flag_denormal_o),
        .flag_inexact_o  (flag_inexact_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic real pow2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real to_real(input logic [15:0] v);
        int e = int'(v[14:10]);
        int f = int'(v[9:0]);
        if (e == 0) return real'(f) * pow2(-24);
        return real'(1024 + f) * pow2(e - 25);
    endfunction

    function automatic int flog2(input real y);
        int k = -30;
        while (pow2(k + 1) <= y) k++;
        return k;
    endfunction

    function automatic void ref_sqrt(input logic [15:0] op, input logic [1:0] rm,
                                     output logic [15:0] res, output logic inv,
                                     output logic den, output logic inx);
        real x, t, ulp, lo, mid, y;
        int  k, k2, frac;
        logic up, exact;
        inv = 1'b0;
        inx = 1'b0;
        den = (op[14:10] == 5'd0) && (op[9:0] != 10'd0);
        if (op[14:10] == 5'h1f && op[9:0] != 0) begin
            res = op | 16'h0200;
            inv = !op[9];
        end else if (op[14:0] == 0) begin
            res = op;
        end else if (op[15]) begin
            res = 16'h7E00;
            inv = 1'b1;
        end else if (op[14:10] == 5'h1f) begin
            res = op;
        end else begin
            x   = to_real(op);
            t   = $sqrt(x);
            k   = flog2(t);
            ulp = pow2(k - 10);
            lo  = $floor(t / ulp) * ulp;
            while (lo * lo > x) lo = lo - ulp;
            while ((lo + ulp) * (lo + ulp) <= x) lo = lo + ulp;
            exact = (lo * lo == x);
            mid   = lo + ulp / 2.0;
            case (rm)
                2'b00: up = (mid * mid < x) ||
                            ((mid * mid == x) && ($rtoi(lo / ulp) % 2 == 1));
                2'b10: up = !exact;
                default: up = 1'b0;
            endcase
            y    = up ? lo + ulp : lo;
            k2   = flog2(y);
            frac = $rtoi(y / pow2(k2 - 10)) - 1024;
            res  = {1'b0, 5'(k2 + 15), 10'(frac)};
            inx  = !exact;
        end
    endfunction

    task automatic push_expect(input logic [15:0] op, input logic [1:0] rm,
                               input string tag);
        exp_t e;
        logic [15:0] r;
        logic a, b, c;
        ref_sqrt(op, rm, r, a, b, c);
        e.res = r; e.inv = a; e.den = b; e.inx = c;
        e.due = cyc + 14;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic issue(input logic [15:0] op, input logic [1:0] rm, input string tag);
        @(negedge clk);
        push_expect(op, rm, tag);
        start_i   = 1'b1;
        operand_i = op;
        rmode_i   = rm;
        @(negedge clk);
        start_i = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic issue_busy(input logic [15:0] op_a, input logic [15:0] op_b);
        @(negedge clk);
        push_expect(op_a, 2'b00, "R2");
        start_i   = 1'b1;
        operand_i = op_a;
        rmode_i   = 2'b00;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i   = 1'b1;   // must be ignored
        operand_i = op_b;
        rmode_i   = 2'b10;
        @(negedge clk);
        start_i = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    // scoreboard monitor
    exp_t  m_e;
    string m_t;
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R2: unexpected done, actual result=%h expected no done", result_o);
            end else begin
                m_e = exp_q.pop_front();
                m_t = tag_q.pop_front();
                n_tests++;
                if ({result_o, flag_invalid_o, flag_denormal_o, flag_inexact_o} !==
                    {m_e.res, m_e.inv, m_e.den, m_e.inx}) begin
                    n_fail++;
                    $display("FAIL %s: actual res=%h inv=%b den=%b inx=%b expected res=%h inv=%b den=%b inx=%b",
                             m_t, result_o, flag_invalid_o, flag_denormal_o, flag_inexact_o,
                             m_e.res, m_e.inv, m_e.den, m_e.inx);
                end
                n_tests++;
                if (cyc != m_e.due) begin   // R1 latency
                    n_fail++;
                    $display("FAIL R1: done at cycle %0d expected %0d", cyc, m_e.due);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual run still busy expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    logic [15:0] lf = 16'hACE1;
    logic [15:0] rop;
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_tests++;
        if ({done_o, result_o, flag_invalid_o, flag_denormal_o, flag_inexact_o} !== '0) begin
            n_fail++;
            $display("FAIL R1: reset outputs actual %b%h%b%b%b expected all zero",
                     done_o, result_o, flag_invalid_o, flag_denormal_o, flag_inexact_o);
        end
        rst = 1'b0;

        for (int m = 0; m < 4; m++) begin
            issue(16'h4400, 2'(m), "R3 exact 4.0");
            issue(16'h3C00, 2'(m), "R3 exact 1.0");
            issue(16'h0400, 2'(m), "R3 min normal");
            issue(16'h4000, 2'(m), "R3/R4 root of 2");
            issue(16'h4200, 2'(m), "R3/R4 root of 3");
            issue(16'h7BFF, 2'(m), "R3/R4 max finite");
            issue(16'h43FF, 2'(m), "R9 carry bump");
        end

        issue(16'h0001, 2'b00, "R5 smallest subnormal");
        issue(16'h0200, 2'b00, "R5 subnormal");
        issue(16'h03FF, 2'b10, "R5 subnormal up");
        issue(16'h0155, 2'b11, "R5 subnormal zero");
        issue(16'h8001, 2'b00, "R5/R7 negative subnormal");

        issue(16'h0000, 2'b00, "R6 +0");
        issue(16'h8000, 2'b10, "R6 -0");

        issue(16'h7C00, 2'b00, "R7 +inf");
        issue(16'hFC00, 2'b00, "R7 -inf");
        issue(16'hBC00, 2'b01, "R7 negative normal");

        issue(16'h7E01, 2'b00, "R8 quiet NaN");
        issue(16'hFE00, 2'b00, "R8 negative quiet NaN");
        issue(16'h7C01, 2'b00, "R8 signaling NaN");
        issue(16'hFD00, 2'b11, "R8 negative signaling NaN");

        issue_busy(16'h4000, 16'h7C01);
        issue(16'h3C00, 2'b00, "R2 idle after busy start");

        for (int i = 0; i < 40; i++) begin
            lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rop = {1'b0, lf[14:0]};
            if (rop[14:10] == 5'h1f) rop[14:10] = 5'h1e;
            issue(rop, lf[1:0] ^ 2'(i), "R3/R4 random");
        end

        repeat (4) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: pending results actual %0d expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule